// File: doc/BRIEF.md
# Dual-Clock FIFO with Hysteretic Status Flags

This block is a 512-word, 9-bit first-in first-out buffer whose write side and read side each run on their own clock. A word is stored on each rising write-clock edge while the active-low write enable is low. A word is presented on the registered output after each rising read-clock edge while the active-low read enable is low. The two clocks may be one shared net or two unrelated clocks. Pointers cross between the domains as Gray codes through synchronizer stages.

Each status flag is registered in the clock domain that owns its condition. Full, half-full and almost-full are decided on write-clock edges. Empty and almost-empty are decided on read-clock edges. A write-clock edge with no write still counts as a flag update cycle. The half-full flag asserts on the write that takes the occupancy past half. It is released only on a write edge at which the write side sees fewer than half the words stored, so leaving it takes two reads from 257. A retransmit strobe rewinds the read position to the first word written since reset so the data can be replayed.

Top module: `hyst_clk_fifo`

## Requirements
- R1: While `mr_n` is low and after its release: `ef_n` is 0 (empty), `hf_n` is 1, `pafe_n` is 0 and `dout` is 0.
- R2: A rising `wclk` edge with `wen_n` low and the buffer not full stores `din`. Holding `wen_n` low stores one word per write cycle.
- R3: A rising `rclk` edge with `ren_n` low and the buffer not empty loads the oldest unread word onto `dout`. Words leave in write order, with tied clocks and with unrelated clocks.
- R4: A write attempted while 512 words are stored is dropped. It does not change the stored words, the count or the write position.
- R5: A read attempted while the buffer is empty is dropped. `dout` keeps its value and the read position does not move.
- R6: `hf_n` goes low on the rising `wclk` edge of the enabled write that takes the count from 256 to 257.
- R7: Once low, `hf_n` rises only on a `wclk` edge, enabled or idle, at which the count seen before that edge is below 256. At a count of 256 it stays low.
- R8: `ef_n` is low when the count is 0 (decided on `rclk`) or 512 (decided on `wclk`), and high otherwise.
- R9: `pafe_n` is low when the count is at most the offset or at least 512 minus the offset. The offset resets to 8 and is loaded from `off_val` on a `wclk` edge with `off_ld` high.
- R10: `rt_n` low on a rising `rclk` edge, with `ren_n` and `wen_n` high, sets the read position back to the first word written since reset. Later reads replay from there. This holds when at most 512 words have been written since reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mr_n | input | 1 | Asynchronous master reset, active low |
| wen_n | input | 1 | Write enable, active low |
| din | input | 9 | Write data |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Retransmit strobe, active low, sampled on `rclk` |
| off_ld | input | 1 | Loads the almost-boundary offset on `wclk` |
| off_val | input | 9 | New almost-boundary offset |
| dout | output | 9 | Registered read data |
| ef_n | output | 1 | Empty-or-full flag, active low |
| hf_n | output | 1 | Half-full flag, active low |
| pafe_n | output | 1 | Almost-empty-or-almost-full flag, active low |

## Verification
The bench targets the half-full band at 255, 256 and 257. A design that released the flag as soon as the count reached 256 would raise `hf_n` one read too early. A design that asserted it at 256 would lower it one write too early. Writes beyond full and reads beyond empty are followed by a complete drain compared against a queue model: a dropped-write bug shows up as a corrupted word, and a read-while-empty bug shows up as a changed `dout`. Retransmit after a partial read must replay from the very first word, not from the current read position. A long run with unrelated clock periods checks that a slow pointer crossing never lets a read overtake a write.

// File: rtl/hyst_fifo_pkg.sv
package hyst_fifo_pkg;

    // Widest pointer the Gray helpers handle; callers zero-extend and slice.
    localparam int GW = 16;

    function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
        logic [GW-1:0] b;
        b[GW-1] = g[GW-1];
        for (int i = GW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/hyst_fifo_sync.sv
module hyst_fifo_sync #(
    parameter int PW     = 10,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] d,
    output logic [PW-1:0] q
);
    logic [PW-1:0] stg_q [STAGES];

    // Stage 0 samples the foreign-domain Gray pointer; later stages add depth.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[0] <= '0;
        else        stg_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg_q[s] <= '0;
            else        stg_q[s] <= stg_q[s-1];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hyst_fifo_ram.sv
module hyst_fifo_ram #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             wclk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Read is combinational; the read side registers the selected word.
    assign rdata = mem[raddr];
endmodule

// File: rtl/hyst_fifo_wr.sv
module hyst_fifo_wr
    import hyst_fifo_pkg::*;
#(
    parameter int DEPTH   = 512,
    parameter int OFF_W   = 9,
    parameter int OFF_DEF = 8,
    localparam int AW     = $clog2(DEPTH),
    localparam int PW     = AW + 1
) (
    input  logic             wclk,
    input  logic             rst_n,
    input  logic             wen_n,
    input  logic             off_ld,
    input  logic [OFF_W-1:0] off_val,
    input  logic [PW-1:0]    rgray_s,
    output logic             we,
    output logic [AW-1:0]    waddr,
    output logic [PW-1:0]    wgray,
    output logic [PW-1:0]    wptr,
    output logic [PW-1:0]    wcount,
    output logic             full,
    output logic             half,
    output logic             afull,
    output logic [OFF_W-1:0] off_q
);
    localparam logic [PW-1:0] FULL_C = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_C = PW'(DEPTH / 2);

    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic [PW-1:0]    gry;
        logic             full;
        logic             half;
        logic             afull;
        logic [OFF_W-1:0] off;
    } wst_t;

    wst_t          s_q, s_d;
    logic [PW-1:0] rbin_d, cnt_d, cnt_n_d, lim_d;
    logic          go_d;

    always_comb begin
        s_d     = s_q;
        rbin_d  = PW'(from_gray(GW'(rgray_s)));
        cnt_d   = s_q.ptr - rbin_d;
        go_d    = !wen_n && (cnt_d != FULL_C);
        cnt_n_d = cnt_d + PW'(go_d);
        lim_d   = FULL_C - PW'(s_q.off);

        s_d.ptr   = s_q.ptr + PW'(go_d);
        s_d.gry   = PW'(to_gray(GW'(s_d.ptr)));
        s_d.full  = (cnt_n_d == FULL_C);
        s_d.afull = (cnt_n_d >= lim_d);

        // Set past half; release only when the pre-edge view is below half.
        if (cnt_n_d > HALF_C)     s_d.half = 1'b1;
        else if (cnt_d < HALF_C)  s_d.half = 1'b0;

        if (off_ld) s_d.off = off_val;
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ptr   <= '0;
            s_q.gry   <= '0;
            s_q.full  <= 1'b0;
            s_q.half  <= 1'b0;
            s_q.afull <= 1'b0;
            s_q.off   <= OFF_W'(OFF_DEF);
        end else begin
            s_q <= s_d;
        end
    end

    assign we     = go_d;
    assign waddr  = s_q.ptr[AW-1:0];
    assign wgray  = s_q.gry;
    assign wptr   = s_q.ptr;
    assign wcount = cnt_d;
    assign full   = s_q.full;
    assign half   = s_q.half;
    assign afull  = s_q.afull;
    assign off_q  = s_q.off;
endmodule

// File: rtl/hyst_fifo_rd.sv
module hyst_fifo_rd
    import hyst_fifo_pkg::*;
#(
    parameter int WIDTH = 9,
    parameter int DEPTH = 512,
    parameter int OFF_W = 9,
    localparam int AW   = $clog2(DEPTH),
    localparam int PW   = AW + 1
) (
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             ren_n,
    input  logic             rt_n,
    input  logic [PW-1:0]    wgray_s,
    input  logic [OFF_W-1:0] off,
    input  logic [WIDTH-1:0] mem_word,
    output logic [AW-1:0]    raddr,
    output logic [PW-1:0]    rgray,
    output logic [PW-1:0]    rptr,
    output logic [PW-1:0]    rcount,
    output logic             empty,
    output logic             aempty,
    output logic [WIDTH-1:0] dout
);
    typedef struct packed {
        logic [PW-1:0]    ptr;
        logic [PW-1:0]    gry;
        logic             empty;
        logic             aempty;
        logic [WIDTH-1:0] dat;
    } rst_t;

    rst_t          s_q, s_d;
    logic [PW-1:0] wbin_d, cnt_d, cnt_n_d;
    logic          go_d, rew_d;

    always_comb begin
        s_d    = s_q;
        wbin_d = PW'(from_gray(GW'(wgray_s)));
        cnt_d  = wbin_d - s_q.ptr;
        rew_d  = !rt_n && ren_n;
        go_d   = !ren_n && (cnt_d != '0);

        if (rew_d) begin
            s_d.ptr = '0;
            cnt_n_d = wbin_d;
        end else begin
            s_d.ptr = s_q.ptr + PW'(go_d);
            cnt_n_d = cnt_d - PW'(go_d);
        end

        s_d.gry    = PW'(to_gray(GW'(s_d.ptr)));
        s_d.empty  = (cnt_n_d == '0);
        s_d.aempty = (cnt_n_d <= PW'(off));
        if (go_d) s_d.dat = mem_word;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.ptr    <= '0;
            s_q.gry    <= '0;
            s_q.empty  <= 1'b1;
            s_q.aempty <= 1'b1;
            s_q.dat    <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign raddr  = s_q.ptr[AW-1:0];
    assign rgray  = s_q.gry;
    assign rptr   = s_q.ptr;
    assign rcount = cnt_d;
    assign empty  = s_q.empty;
    assign aempty = s_q.aempty;
    assign dout   = s_q.dat;
endmodule

// File: rtl/hyst_clk_fifo.sv
module hyst_clk_fifo #(
    parameter int DEPTH       = 512,
    parameter int WIDTH       = 9,
    parameter int OFF_W       = $clog2(DEPTH),
    parameter int OFF_DEF     = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             mr_n,
    input  logic             wen_n,
    input  logic [WIDTH-1:0] din,
    input  logic             ren_n,
    input  logic             rt_n,
    input  logic             off_ld,
    input  logic [OFF_W-1:0] off_val,
    output logic [WIDTH-1:0] dout,
    output logic             ef_n,
    output logic             hf_n,
    output logic             pafe_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic             we_w, full_w, half_w, afull_w, empty_r, aempty_r;
    logic [AW-1:0]    waddr_w, raddr_r;
    logic [PW-1:0]    wgray_w, wptr_w, wcount_w, rgray_r, rptr_r, rcount_r;
    logic [PW-1:0]    wgray_s, rgray_s;
    logic [OFF_W-1:0] off_w;
    logic [WIDTH-1:0] mem_word;

    hyst_fifo_wr #(.DEPTH(DEPTH), .OFF_W(OFF_W), .OFF_DEF(OFF_DEF)) u_wr (
        .wclk(wclk), .rst_n(mr_n), .wen_n(wen_n), .off_ld(off_ld),
        .off_val(off_val), .rgray_s(rgray_s), .we(we_w), .waddr(waddr_w),
        .wgray(wgray_w), .wptr(wptr_w), .wcount(wcount_w), .full(full_w),
        .half(half_w), .afull(afull_w), .off_q(off_w)
    );

    hyst_fifo_rd #(.WIDTH(WIDTH), .DEPTH(DEPTH), .OFF_W(OFF_W)) u_rd (
        .rclk(rclk), .rst_n(mr_n), .ren_n(ren_n), .rt_n(rt_n),
        .wgray_s(wgray_s), .off(off_w), .mem_word(mem_word),
        .raddr(raddr_r), .rgray(rgray_r), .rptr(rptr_r), .rcount(rcount_r),
        .empty(empty_r), .aempty(aempty_r), .dout(dout)
    );

    hyst_fifo_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk(rclk), .rst_n(mr_n), .d(wgray_w), .q(wgray_s)
    );

    hyst_fifo_sync #(.PW(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk(wclk), .rst_n(mr_n), .d(rgray_r), .q(rgray_s)
    );

    hyst_fifo_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
        .wclk(wclk), .we(we_w), .waddr(waddr_w), .wdata(din),
        .raddr(raddr_r), .rdata(mem_word)
    );

    assign ef_n   = ~(empty_r | full_w);
    assign hf_n   = ~half_w;
    assign pafe_n = ~(aempty_r | afull_w);
endmodule

// File: rtl/hyst_clk_fifo_chk.sv
module hyst_clk_fifo_chk #(
    parameter int DEPTH = 512,
    parameter int WIDTH = 9,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input logic             wclk,
    input logic             rclk,
    input logic             mr_n,
    input logic             wen_n,
    input logic             ren_n,
    input logic             rt_n,
    input logic             hf_n,
    input logic             ef_n,
    input logic [WIDTH-1:0] dout,
    input logic [PW-1:0]    wptr,
    input logic [PW-1:0]    rptr,
    input logic [PW-1:0]    wcount,
    input logic [PW-1:0]    rcount
);
    localparam logic [PW-1:0] FULL_C = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_C = PW'(DEPTH / 2);

    // R2
    wr_step_chk: assert property (@(posedge wclk) disable iff (!mr_n)
        (!wen_n && wcount < FULL_C) |=> wptr == ($past(wptr) + 1'b1));

    // R4
    full_drop_chk: assert property (@(posedge wclk) disable iff (!mr_n)
        (!wen_n && wcount == FULL_C) |=> $stable(wptr));

    // R5
    empty_drop_chk: assert property (@(posedge rclk) disable iff (!mr_n)
        (!ren_n && rcount == '0) |=> ($stable(dout) && $stable(rptr)));

    // R6
    hf_set_chk: assert property (@(posedge wclk) disable iff (!mr_n)
        (!wen_n && wcount == HALF_C) |=> !hf_n);

    // R7
    hf_keep_chk: assert property (@(posedge wclk) disable iff (!mr_n)
        (!hf_n && wcount >= HALF_C) |=> !hf_n);

    // R8
    full_flag_chk: assert property (@(posedge wclk) disable iff (!mr_n)
        (!wen_n && wcount == FULL_C - 1'b1) |=> !ef_n);

    // R10
    rewind_chk: assert property (@(posedge rclk) disable iff (!mr_n)
        (!rt_n && ren_n) |=> rptr == '0);
endmodule

bind hyst_clk_fifo hyst_clk_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .wclk(wclk), .rclk(rclk), .mr_n(mr_n), .wen_n(wen_n), .ren_n(ren_n),
    .rt_n(rt_n), .hf_n(hf_n), .ef_n(ef_n), .dout(dout), .wptr(wptr_w),
    .rptr(rptr_r), .wcount(wcount_w), .rcount(rcount_r)
);

// File: tb/hyst_clk_fifo_tb_top.sv
module hyst_clk_fifo_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RD_PERIOD  = 14;
    localparam int DEPTH      = 512;
    localparam int HALF       = DEPTH / 2;

    logic       wclk = 1'b0, rclk_free = 1'b0, tie = 1'b1;
    logic       rclk;
    logic       mr_n = 1'b0, wen_n = 1'b1, ren_n = 1'b1, rt_n = 1'b1, off_ld = 1'b0;
    logic [8:0] din = '0, off_val = '0, dout;
    logic       ef_n, hf_n, pafe_n;

    int         total = 0, bad = 0, off_cur = 8;
    logic [8:0] wseq = 9'h0A5;
    logic [8:0] q[$], hist[$];
    logic [8:0] last = '0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RD_PERIOD / 2) rclk_free = ~rclk_free;
    assign rclk = tie ? wclk : rclk_free;

    hyst_clk_fifo dut_i (
        .wclk(wclk), .rclk(rclk), .mr_n(mr_n), .wen_n(wen_n), .din(din),
        .ren_n(ren_n), .rt_n(rt_n), .off_ld(off_ld), .off_val(off_val),
        .dout(dout), .ef_n(ef_n), .hf_n(hf_n), .pafe_n(pafe_n)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic t);
        mr_n = 1'b0; wen_n = 1'b1; ren_n = 1'b1; rt_n = 1'b1; off_ld = 1'b0;
        tie = t;
        repeat (4) @(negedge wclk);
        q.delete(); hist.delete(); off_cur = 8; last = '0;
        mr_n = 1'b1;
        repeat (2) @(negedge wclk);
    endtask

    task automatic wr_burst(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge wclk);
            wen_n = 1'b0; din = wseq; wseq = wseq + 9'd37;
            @(posedge wclk);
            if (q.size() < DEPTH) begin
                q.push_back(din); hist.push_back(din);
            end
        end
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    task automatic rd_burst(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            logic [8:0] exp;
            bit         hit;
            @(negedge rclk);
            ren_n = 1'b0;
            @(posedge rclk);
            hit = (q.size() > 0);
            exp = hit ? q.pop_front() : last;
            @(negedge rclk);
            ren_n = 1'b1;
            // R5 when the model is empty: output must hold
            check(dout == exp, hit ? tag : "R5", dout, exp);
            last = exp;
        end
    endtask

    task automatic settle();
        wen_n = 1'b1; ren_n = 1'b1;
        repeat (12) @(negedge wclk);
        repeat (12) @(negedge rclk);
    endtask

    task automatic check_flags(input string tag);
        int  c;
        bit  e_ef, e_pafe;
        c      = q.size();
        e_ef   = !(c == 0 || c == DEPTH);
        e_pafe = !(c <= off_cur || c >= DEPTH - off_cur);
        check(ef_n == e_ef, tag, ef_n, e_ef);
        check(pafe_n == e_pafe, tag, pafe_n, e_pafe);
        if (c != HALF) check(hf_n == (c < HALF), tag, hf_n, c < HALF);
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        do_reset(1'b1);
        // R1 reset state
        check(ef_n == 1'b0, "R1", ef_n, 0);
        check(hf_n == 1'b1, "R1", hf_n, 1);
        check(pafe_n == 1'b0, "R1", pafe_n, 0);
        check(dout == 9'd0, "R1", dout, 0);

        // R9 default offset of 8 at counts 8 and 9
        wr_burst(8); settle(); check_flags("R9");
        wr_burst(1); settle(); check_flags("R9");

        // R6 half-full boundary
        wr_burst(HALF - 9); settle();
        check(hf_n == 1'b1, "R6", hf_n, 1);
        wr_burst(1);
        check(hf_n == 1'b0, "R6", hf_n, 0);
        settle();

        // R7 hysteresis: 257 -> 256 keeps, write back to 257 keeps, 255 releases
        rd_burst(1, "R3"); settle();
        check(hf_n == 1'b0, "R7", hf_n, 0);
        wr_burst(1); settle();
        check(hf_n == 1'b0, "R7", hf_n, 0);
        rd_burst(2, "R3"); settle();
        check(hf_n == 1'b1, "R7", hf_n, 1);

        // R4 and R8: fill past full, then drain past empty
        wr_burst(DEPTH - q.size() + 3); settle();
        check(q.size() == DEPTH, "R4", q.size(), DEPTH);
        check_flags("R8");
        rd_burst(DEPTH + 2, "R4"); settle();
        check_flags("R8");

        // R10 retransmit after a partial read
        do_reset(1'b1);
        wr_burst(20); settle();
        rd_burst(5, "R2"); settle();
        @(negedge rclk); rt_n = 1'b0;
        @(negedge rclk); rt_n = 1'b1;
        q = hist;
        settle(); check_flags("R10");
        rd_burst(20, "R10"); settle();
        check_flags("R10");

        // R9 programmed offset of 3
        do_reset(1'b1);
        @(negedge wclk); off_ld = 1'b1; off_val = 9'd3;
        @(negedge wclk); off_ld = 1'b0; off_cur = 3;
        wr_burst(3); settle(); check_flags("R9");
        wr_burst(1); settle(); check_flags("R9");

        // R3 unrelated clocks, concurrent traffic
        do_reset(1'b0);
        fork
            begin : writer
                for (int i = 0; i < 1400; i++) begin
                    bit en;
                    @(negedge wclk);
                    en = ($urandom_range(0, 3) != 0) && (q.size() < DEPTH - 16);
                    wen_n = !en; din = wseq; wseq = wseq + 9'd37;
                    @(posedge wclk);
                    if (en) q.push_back(din);
                end
                @(negedge wclk); wen_n = 1'b1;
            end
            begin : reader
                bit         pend = 1'b0;
                logic [8:0] exp = '0;
                for (int i = 0; i < 1000; i++) begin
                    bit en;
                    @(negedge rclk);
                    if (pend) check(dout == exp, "R3", dout, exp);
                    pend = 1'b0;
                    en = ($urandom_range(0, 3) != 0) && (q.size() > 16);
                    ren_n = !en;
                    @(posedge rclk);
                    if (en) begin exp = q.pop_front(); pend = 1'b1; end
                end
                @(negedge rclk);
                if (pend) check(dout == exp, "R3", dout, exp);
                ren_n = 1'b1;
                last = exp;
            end
        join
        settle(); check_flags("R3");
        rd_burst(q.size(), "R3"); settle();
        check_flags("R8");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule